// File: doc/BRIEF.md
# Thermometer-to-Gray Decoder with Bubble Suppression

This block turns the 255-line thermometer word produced by a bank of flash comparators into an 8-bit Gray-coded sample plus an overflow flag. Line `i` of the word is high when the sampled input lies beyond reference tap `i`. In a clean word the high lines form one contiguous run starting at line 0, so the sample level equals the number of high lines.

A three-input majority vote is taken at every line before decoding. A single wrong comparator output, such as a metastable "bubble", therefore moves the result by at most one step. The filtered word is cut into four columns of 64 lines. Each column decoder finds the last high line in its column and reports a 6-bit fine value and a column-full flag. These 28 bits are registered on the falling clock edge. On the rising edge, the first column that is not full gives the two coarse bits and selects the fine value. The 8-bit level is then converted to Gray code and registered together with the overflow flag.

A word presented after a rising edge appears at the outputs on the next rising edge. The reset is asynchronous and active low, and the block synchronises its release internally.

Top module: `thermo_gray_dec`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `code_o` is all zeros. `valid_o` stays 0 for at least the first rising edge after `rst_ni` goes high.
- R2: For a clean word of level L (lines 0..L-1 high, all others low, L in 0..255), `code_o[7:0]` equals L XOR (L >> 1), with bit 7 as the most significant bit.
- R3: `code_o[8]` is the overflow flag. It is 1 exactly when the decoded level is 255, which the all-ones word gives. When it is 1, `code_o[7:0]` is 8'h80.
- R4: The all-zero word gives `code_o` equal to 9'h000, with overflow clear.
- R5: A clean word of level L with any single line inverted decodes, after Gray-to-binary conversion, to a level within 1 of L.
- R6: The result is exactly L when a single inverted line p lies at least two lines away from the run boundary on either side, that is p <= L-3 or p >= L+2.
- R7: A word driven after rising edge n shows at the outputs after rising edge n+1. Between those edges, including across the falling edge, the outputs keep their previous value.
- R8: Once `valid_o` is 1, it stays 1 until reset is asserted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock. Column results are captured on its falling edge and the output on its rising edge. |
| rst_ni | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| therm_i | input | 255 | Comparator thermometer word. Line 0 is the tap nearest the low end of the input range. |
| code_o | output | 9 | Bit 8 is overflow. Bits 7..0 are the Gray-coded level. |
| valid_o | output | 1 | High once the pipeline holds a result taken after reset. |

## Verification
Every stage has only one register between it and the ports. A wrong column-full flag or fine value therefore shows at the very next rising edge, as a level off by a multiple of 64 or by an arbitrary fine amount. A fault in the majority vote or in the boundary detection shows as an error of two or more levels, or as a non-exact result when the bubble lies far from the run boundary. For this reason every clean level and every single-line bubble at every level is applied and decoded back to binary in the bench. The check on the value held across the falling edge catches a result that appears too early, or one that is delayed by an extra stage.

// File: rtl/tgd_pkg.sv
package tgd_pkg;
  // Default split: 2**FINE bits per column, 2**COARSE columns.
  localparam int unsigned TGD_FINE_BITS_DEF   = 6;
  localparam int unsigned TGD_COARSE_BITS_DEF = 2;

  // Number of thermometer lines for a given split (one line short of full).
  function automatic int unsigned tgd_therm_width(input int unsigned fine_bits,
                                                  input int unsigned coarse_bits);
    return (1 << (fine_bits + coarse_bits)) - 1;
  endfunction
endpackage

// File: rtl/tgd_bubble_filter.sv
module tgd_bubble_filter #(
  parameter int unsigned W = 255
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] clean_o
);
  // Virtual line below 0 reads high, virtual line above W-1 reads low.
  logic [W+1:0] ext;
  assign ext = {1'b0, raw_i, 1'b1};

  for (genvar i = 0; i < W; i++) begin : g_vote
    // Majority of the line and its two neighbours.
    assign clean_o[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
  end
endmodule

// File: rtl/tgd_col_dec.sv
module tgd_col_dec #(
  parameter int unsigned FINE_BITS = 6
) (
  input  logic [(1<<FINE_BITS)-1:0] col_i,
  output logic [FINE_BITS-1:0]      fine_o,
  output logic                      full_o
);
  localparam int unsigned COL_W = 1 << FINE_BITS;

  // One-hot marker on the last high line of the run inside this column.
  logic [COL_W-1:0] hit;

  for (genvar j = 0; j < COL_W - 1; j++) begin : g_edge
    assign hit[j] = col_i[j] & ~col_i[j+1];
  end
  assign hit[COL_W-1] = col_i[COL_W-1];

  // OR-encode (index + 1); a full column wraps to zero.
  always_comb begin
    fine_o = '0;
    for (int j = 0; j < COL_W; j++) begin
      if (hit[j]) begin
        fine_o = fine_o | FINE_BITS'(j + 1);
      end
    end
  end

  assign full_o = col_i[COL_W-1];
endmodule

// File: rtl/tgd_merge.sv
module tgd_merge #(
  parameter int unsigned FINE_BITS   = 6,
  parameter int unsigned COARSE_BITS = 2
) (
  input  logic [(1<<COARSE_BITS)*FINE_BITS-1:0] fine_i,
  input  logic [(1<<COARSE_BITS)-1:0]           full_i,
  output logic [FINE_BITS+COARSE_BITS-1:0]      gray_o,
  output logic                                  ovf_o
);
  localparam int unsigned NUM_COLS = 1 << COARSE_BITS;
  localparam int unsigned CODE_W   = FINE_BITS + COARSE_BITS;

  logic [COARSE_BITS-1:0] coarse;
  logic                   found;
  logic [FINE_BITS-1:0]   fine_sel;
  logic [CODE_W-1:0]      bin;

  // The first column that is not full holds the run boundary.
  always_comb begin
    coarse = '1;
    found  = 1'b0;
    for (int c = 0; c < NUM_COLS; c++) begin
      if (!found && !full_i[c]) begin
        coarse = COARSE_BITS'(c);
        found  = 1'b1;
      end
    end
  end

  assign fine_sel = fine_i[int'(coarse)*FINE_BITS +: FINE_BITS];
  assign bin      = {coarse, fine_sel};
  assign ovf_o    = &bin;
  assign gray_o   = bin ^ (bin >> 1);
endmodule

// File: rtl/thermo_gray_dec.sv
module thermo_gray_dec
  import tgd_pkg::*;
#(
  parameter int unsigned FINE_BITS   = TGD_FINE_BITS_DEF,
  parameter int unsigned COARSE_BITS = TGD_COARSE_BITS_DEF,
  localparam int unsigned CODE_W     = FINE_BITS + COARSE_BITS,
  localparam int unsigned THERM_W    = (1 << CODE_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [THERM_W-1:0] therm_i,
  output logic [CODE_W:0]    code_o,
  output logic               valid_o
);
  localparam int unsigned COL_W    = 1 << FINE_BITS;
  localparam int unsigned NUM_COLS = 1 << COARSE_BITS;

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // ---------------- bubble suppression ----------------
  logic [THERM_W-1:0] clean;
  logic [THERM_W:0]   padded;

  tgd_bubble_filter #(.W(THERM_W)) u_filter (
    .raw_i   (therm_i),
    .clean_o (clean)
  );
  assign padded = {1'b0, clean};

  // ---------------- column decoders ----------------
  logic [NUM_COLS*FINE_BITS-1:0] fine_d, fine_q;
  logic [NUM_COLS-1:0]           full_d, full_q;
  logic                          col_vld_d, col_vld_q;
  logic                          col_en;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    tgd_col_dec #(.FINE_BITS(FINE_BITS)) u_col (
      .col_i  (padded[c*COL_W +: COL_W]),
      .fine_o (fine_d[c*FINE_BITS +: FINE_BITS]),
      .full_o (full_d[c])
    );
  end

  assign col_en    = 1'b1;
  assign col_vld_d = 1'b1;

  // Column results captured on the falling edge.
  always_ff @(negedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fine_q    <= '0;
      full_q    <= '0;
      col_vld_q <= 1'b0;
    end else if (col_en) begin
      fine_q    <= fine_d;
      full_q    <= full_d;
      col_vld_q <= col_vld_d;
    end
  end

  // ---------------- coarse select and Gray stage ----------------
  logic [CODE_W-1:0] gray_d;
  logic              ovf_d;
  logic [CODE_W:0]   code_d, code_q;
  logic              out_en;
  logic              valid_q;

  tgd_merge #(.FINE_BITS(FINE_BITS), .COARSE_BITS(COARSE_BITS)) u_merge (
    .fine_i (fine_q),
    .full_i (full_q),
    .gray_o (gray_d),
    .ovf_o  (ovf_d)
  );

  assign code_d = {ovf_d, gray_d};
  assign out_en = col_vld_q;

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else if (out_en) begin
      code_q  <= code_d;
      valid_q <= 1'b1;
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/thermo_gray_dec_chk.sv
module thermo_gray_dec_chk #(
  parameter int unsigned FINE_BITS   = 6,
  parameter int unsigned COARSE_BITS = 2,
  localparam int unsigned CODE_W     = FINE_BITS + COARSE_BITS,
  localparam int unsigned THERM_W    = (1 << CODE_W) - 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [THERM_W-1:0] therm_i,
  input logic [CODE_W:0]    code_o,
  input logic               valid_o
);
  logic [THERM_W-1:0] plus1;
  logic               in_clean;
  logic               in_full;
  logic [CODE_W:0]    in_ones;
  logic [CODE_W-1:0]  out_bin;

  assign plus1    = therm_i + THERM_W'(1);
  assign in_clean = ((therm_i & plus1) == '0);
  assign in_full  = &therm_i;
  assign in_ones  = (CODE_W+1)'($countones(therm_i));

  always_comb begin
    out_bin[CODE_W-1] = code_o[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      out_bin[i] = out_bin[i+1] ^ code_o[i];
    end
  end

  // R1: reset holds the outputs idle
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && code_o == '0));

  // R2: clean word decodes to its level one edge later
  p_clean_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(in_clean)) |-> ({1'b0, out_bin} == $past(in_ones)));

  // R3: overflow comes with the top Gray code
  p_ovf_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && code_o[CODE_W]) |-> (code_o[CODE_W-1:0] == {1'b1, {(CODE_W-1){1'b0}}}));

  // R3: all-ones word raises overflow
  p_ovf_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(in_full)) |-> code_o[CODE_W]);

  // R8: valid holds once set
  p_valid_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

bind thermo_gray_dec thermo_gray_dec_chk #(
  .FINE_BITS   (FINE_BITS),
  .COARSE_BITS (COARSE_BITS)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .therm_i (therm_i),
  .code_o  (code_o),
  .valid_o (valid_o)
);

// File: tb/thermo_gray_dec_tb_top.sv
module thermo_gray_dec_tb_top;
  localparam int THERM_W = 255;

  logic               clk = 1'b0;
  logic               rst_n = 1'b1;
  logic [THERM_W-1:0] therm = '0;
  logic [8:0]         code;
  logic               valid;
  int                 checks = 0;
  int                 failures = 0;
  bit                 done = 1'b0;

  always #10 clk = ~clk;

  thermo_gray_dec dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .therm_i (therm),
    .code_o  (code),
    .valid_o (valid)
  );

  function automatic logic [THERM_W-1:0] level_word(input int lvl);
    logic [THERM_W:0] t;
    t = ((THERM_W+1)'(1) << lvl) - (THERM_W+1)'(1);
    return t[THERM_W-1:0];
  endfunction

  function automatic int gray_to_level(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return int'(b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #3 rst_n = 1'b0;
    therm = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    chk(code == 9'h000, "R1 code in reset", int'(code), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(valid == 1'b0, "R1 valid right after release", int'(valid), 0);
    repeat (4) @(posedge clk);
    #1;
    chk(valid == 1'b1, "R8 valid after fill", int'(valid), 1);
    chk(code == 9'h000, "R4 all-zero word", int'(code), 0);

    // Clean sweep over every level, with the hold check across the falling edge.
    begin
      int prev;
      prev = 0;
      for (int lvl = 0; lvl < 256; lvl++) begin
        int exp_g;
        therm = level_word(lvl);
        @(negedge clk); #1;
        chk(int'(code) == prev, "R7 output held before rising edge", int'(code), prev);
        @(posedge clk); #1;
        exp_g = lvl ^ (lvl >> 1);
        chk(int'(code[7:0]) == exp_g, "R2 clean level Gray code", int'(code[7:0]), exp_g);
        chk(code[8] == (lvl == 255), "R3 overflow on clean word", int'(code[8]), int'(lvl == 255));
        if (lvl == 0) chk(code == 9'h000, "R4 zero word code", int'(code), 0);
        if (lvl == 255) chk(code[7:0] == 8'h80, "R3 overflow Gray value", int'(code[7:0]), 128);
        chk(valid == 1'b1, "R8 valid stays high", int'(valid), 1);
        prev = int'(code);
      end
    end

    // Every single-line bubble at every level.
    for (int lvl = 0; lvl < 256; lvl++) begin
      for (int p = 0; p < THERM_W; p++) begin
        int dec, diff;
        therm = level_word(lvl) ^ (THERM_W'(1) << p);
        @(posedge clk); #1;
        dec  = gray_to_level(code[7:0]);
        diff = (dec > lvl) ? dec - lvl : lvl - dec;
        chk(diff <= 1, "R5 bubble error within one step", dec, lvl);
        if ((p <= lvl - 3) || (p >= lvl + 2))
          chk(dec == lvl, "R6 distant bubble exact", dec, lvl);
        chk(code[8] == (dec == 255), "R3 overflow matches level", int'(code[8]), int'(dec == 255));
      end
    end

    // Reset again: outputs return to idle.
    @(posedge clk); #1;
    rst_n = 1'b0;
    #2;
    chk(valid == 1'b0, "R1 valid on reassert", int'(valid), 0);
    chk(code == 9'h000, "R1 code on reassert", int'(code), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule